// File: doc/BRIEF.md
# Two-Entry Decoupling Stream Stage

This block is one register stage on a valid/ready stream. It sits between a producer and a consumer that share a clock. Every signal that leaves the block comes straight from a flop. No combinational path joins the input port to the output port in either direction. A long chain of stages can therefore be built without the ready signals combining into one long timing path.

Inside there are two single-entry slots. The first is an output register that always drives the downstream port. The second is a skid slot that catches one item when downstream stalls.

- While the skid slot is empty, incoming items go around it and straight into the output register whenever that register is free or being drained.
- When the output register is stuck, one more item is parked in the skid slot.
- The upstream ready is simply the inverse of the skid slot's occupancy. It is never taken from the downstream ready.

Back-pressure rules:

- A transfer happens on a port only in a cycle where valid and ready are both high.
- Upstream may hold or drop valid at will.
- Once the output valid is high, it stays high with unchanged data until the consumer takes the item.

The block never holds more than two items. It never reorders, drops or repeats an item.

Top module: `skid_decoupler`

## Requirements
- R1: After a cycle with `rst` high, `out_valid` is 0 and `in_ready` is 1. Both slots are empty.
- R2: Items leave in the order they were accepted. None is lost or duplicated, and the data is passed unchanged.
- R3: The block holds at most two items. `in_ready` is low exactly when two items are held.
- R4: An item accepted while the block is empty is presented on `out_valid`/`out_data` in the next cycle.
- R5: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high with the same `out_data`.
- R6: `in_ready`, `out_valid` and `out_data` do not change within a cycle when `in_valid`, `in_data` or `out_ready` change. They depend only on state held in flops.
- R7: If the output register is full and stalled while the skid slot is empty, one more item is accepted. `in_ready` is then low in the following cycle.
- R8: If `in_ready` is low and the consumer takes an item, `in_ready` is high again in the next cycle.
- R9: With `in_valid` and `out_ready` held high, one item passes per cycle after the first, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Stage can accept an item; registered |
| in_data | input | DATA_W | Incoming item |
| out_valid | output | 1 | Output register holds an item; registered |
| out_ready | input | 1 | Consumer takes the item this cycle |
| out_data | output | DATA_W | Item at the head of the stage; registered |

## Verification
The hardest state to reach is the one where both slots are full. The consumer must stall for two cycles while the producer keeps offering items, and then be released exactly as the skid slot must hand its item forward ahead of the waiting input.

The stimulus reaches this state in two ways:

- A directed sequence stalls the consumer for two cycles with the producer pushing, then releases it.
- A long random phase varies the chances of valid and ready from mostly idle to mostly stalled.

A behavioural queue is compared with the outputs on every cycle. The comparison is made after the inputs change mid-cycle, so a combinational leak would show up as a mismatch.

// File: rtl/skid_decoupler_pkg.sv
package skid_decoupler_pkg;

  // Where the output register takes its next item from.
  typedef enum logic [1:0] {
    OSRC_HOLD  = 2'd0,
    OSRC_INPUT = 2'd1,
    OSRC_SKID  = 2'd2
  } out_src_e;

  // Write command for one single-entry slot.
  typedef struct packed {
    logic we;
    logic next_valid;
  } slot_cmd_t;

endpackage

// File: rtl/sd_slot.sv
module sd_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              next_valid,
  input  logic [DATA_W-1:0] d,
  output logic              valid,
  output logic [DATA_W-1:0] q
);

  // Occupancy flag: cleared by reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (we) begin
      valid <= next_valid;
    end
  end

  // Payload: no reset, written only when a real item arrives.
  always_ff @(posedge clk) begin
    if (we && next_valid) begin
      q <= d;
    end
  end

endmodule

// File: rtl/sd_src_mux.sv
module sd_src_mux
  import skid_decoupler_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  out_src_e          sel,
  input  logic [DATA_W-1:0] from_input,
  input  logic [DATA_W-1:0] from_skid,
  input  logic [DATA_W-1:0] from_hold,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (sel)
      OSRC_INPUT: y = from_input;
      OSRC_SKID:  y = from_skid;
      default:    y = from_hold;
    endcase
  end

endmodule

// File: rtl/sd_ctrl.sv
module sd_ctrl
  import skid_decoupler_pkg::*;
(
  input  logic      in_valid,
  input  logic      out_ready,
  input  logic      skid_full,
  input  logic      out_full,
  output slot_cmd_t skid_cmd,
  output slot_cmd_t out_cmd,
  output out_src_e  out_src
);

  logic out_open;

  // Output register may take a new item when empty or being drained.
  assign out_open = !out_full || out_ready;

  always_comb begin
    skid_cmd = '{we: 1'b0, next_valid: 1'b0};
    out_cmd  = '{we: 1'b0, next_valid: 1'b0};
    out_src  = OSRC_HOLD;
    if (skid_full) begin
      // Input is refused; parked item moves forward first.
      if (out_open) begin
        out_cmd  = '{we: 1'b1, next_valid: 1'b1};
        out_src  = OSRC_SKID;
        skid_cmd = '{we: 1'b1, next_valid: 1'b0};
      end
    end else if (out_open) begin
      // Bypass: input goes straight to the output register.
      out_cmd = '{we: 1'b1, next_valid: in_valid};
      out_src = in_valid ? OSRC_INPUT : OSRC_HOLD;
    end else if (in_valid) begin
      // Output stalled: park one item.
      skid_cmd = '{we: 1'b1, next_valid: 1'b1};
    end
  end

endmodule

// File: rtl/skid_decoupler.sv
module skid_decoupler
  import skid_decoupler_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  slot_cmd_t         skid_cmd;
  slot_cmd_t         out_cmd;
  out_src_e          out_src;
  logic              skid_full;
  logic [DATA_W-1:0] skid_q;
  logic [DATA_W-1:0] out_d;

  sd_ctrl u_ctrl (
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .skid_full (skid_full),
    .out_full  (out_valid),
    .skid_cmd  (skid_cmd),
    .out_cmd   (out_cmd),
    .out_src   (out_src)
  );

  sd_slot #(.DATA_W(DATA_W)) u_skid (
    .clk        (clk),
    .rst        (rst),
    .we         (skid_cmd.we),
    .next_valid (skid_cmd.next_valid),
    .d          (in_data),
    .valid      (skid_full),
    .q          (skid_q)
  );

  sd_src_mux #(.DATA_W(DATA_W)) u_mux (
    .sel        (out_src),
    .from_input (in_data),
    .from_skid  (skid_q),
    .from_hold  (out_data),
    .y          (out_d)
  );

  sd_slot #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .we         (out_cmd.we),
    .next_valid (out_cmd.next_valid),
    .d          (out_d),
    .valid      (out_valid),
    .q          (out_data)
  );

  // Upstream ready comes only from the skid flag.
  assign in_ready = !skid_full;

endmodule

// File: rtl/skid_decoupler_chk.sv
module skid_decoupler_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);

  logic [2:0] held;
  logic       in_fire;
  logic       out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  // Occupancy counted from port handshakes only.
  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 3'd0;
    end else begin
      held <= held + {2'b0, in_fire} - {2'b0, out_fire};
    end
  end

  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  a_r3_max_two: assert property (@(posedge clk) disable iff (rst)
    held <= 3'd2);

  a_r3_ready_vs_held: assert property (@(posedge clk) disable iff (rst)
    (!in_ready) == (held == 3'd2));

  a_r4_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (in_fire && !out_valid) |=> (out_valid && out_data == $past(in_data)));

  a_r5_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_park_one: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && in_fire) |=> !in_ready);

  a_r8_ready_back: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && out_ready && out_valid) |=> in_ready);

  a_r9_no_bubble: assert property (@(posedge clk) disable iff (rst)
    (in_fire && out_fire) |=> (in_ready && out_valid));

endmodule

bind skid_decoupler skid_decoupler_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_skid_decoupler.sv
`timescale 1ns/1ps
module tb_skid_decoupler;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic              in_ready;
  logic [DATA_W-1:0] in_data;
  logic              out_valid;
  logic              out_ready;
  logic [DATA_W-1:0] out_data;

  always #2.5 clk = ~clk;

  skid_decoupler #(.DATA_W(DATA_W)) dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  int                n_chk  = 0;
  int                n_bad  = 0;
  int                n_in   = 0;
  int                n_out  = 0;
  logic [DATA_W-1:0] seq    = '0;
  logic [DATA_W-1:0] mq[$];
  bit                done   = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare after the change, update the model.
  task automatic step(input bit iv, input bit ordy);
    bit fin;
    bit fout;
    in_valid  = iv;
    in_data   = seq;
    out_ready = ordy;
    #1;
    check(in_ready === (mq.size() < 2), "R3/R6 in_ready", in_ready, mq.size() < 2);
    check(out_valid === (mq.size() > 0), "R6 out_valid", out_valid, mq.size() > 0);
    if (mq.size() > 0)
      check(out_data === mq[0], "R2 out_data", out_data, mq[0]);
    fin  = iv && (mq.size() < 2);
    fout = ordy && (mq.size() > 0);
    if (fout) begin
      void'(mq.pop_front());
      n_out++;
    end
    if (fin) begin
      mq.push_back(seq);
      seq++;
      n_in++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [DATA_W-1:0] held_val;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: empty after reset
    check(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready === 1'b1, "R1 in_ready", in_ready, 1);

    // R4: single item from empty appears next cycle
    step(1, 0);
    check(out_valid === 1'b1, "R4 out_valid", out_valid, 1);
    check(out_data === seq - 1'b1, "R4 out_data", out_data, seq - 1'b1);

    // R7: output stalled, one more parked, then ready drops
    held_val = out_data;
    step(1, 0);
    check(in_ready === 1'b0, "R7 in_ready", in_ready, 0);
    // R5: stalled with producer pushing: data stays
    step(1, 0);
    step(1, 0);
    check(out_valid === 1'b1 && out_data === held_val, "R5 hold", out_data, held_val);
    check(in_ready === 1'b0, "R3 full", in_ready, 0);
    // R8: consumer takes one, ready returns next cycle
    step(0, 1);
    check(in_ready === 1'b1, "R8 in_ready", in_ready, 1);
    check(out_data === held_val + 1'b1, "R2 skid forwarded", out_data, held_val + 1'b1);
    repeat (3) step(0, 1);
    check(out_valid === 1'b0, "R2 drained", out_valid, 0);

    // R9: streaming with both sides open
    step(1, 1);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (in_ready && out_valid) cnt++;
      step(1, 1);
    end
    check(cnt == 20, "R9 no bubble", cnt, 20);
    repeat (3) step(0, 1);

    // Random phases with varied valid/ready density
    for (int ph = 0; ph < 4; ph++) begin
      int pv;
      int pr;
      pv = (ph == 0) ? 20 : (ph == 1) ? 90 : (ph == 2) ? 50 : 80;
      pr = (ph == 0) ? 80 : (ph == 1) ? 20 : (ph == 2) ? 50 : 40;
      for (int i = 0; i < 1500; i++)
        step($urandom_range(99) < pv, $urandom_range(99) < pr);
    end

    repeat (4) step(0, 1);
    check(n_in == n_out, "R2 count", n_out, n_in);
    check(out_valid === 1'b0, "R2 empty at end", out_valid, 0);

    // R1: reset while holding items empties the stage
    step(1, 0);
    step(1, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mq.delete();
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 reset flush", out_valid, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule